// File: doc/BRIEF.md
# Address-Programmable Digital Delay Line

This block delays a single-bit signal by a whole number of clock cycles. The delay is chosen by a 5-bit address. It equals a fixed base latency plus the address multiplied by a step size, and both the base latency and the step size are elaboration-time parameters counted in cycles. Every incoming bit is captured into a shift register that is long enough for the largest setting. The output is a tap on that register, selected by the address.

The address is used exactly as presented, with no capture register. Moving it re-points the output tap in the same cycle to history that is already stored. An active-high disable input forces the output low. It acts only on the output, so the stored history keeps advancing while the output is disabled. A synchronous reset empties the line.

Top module: `delay_line_prog`

## Requirements
- R1: `addr` is 5 bits wide and selects one of 32 settings, 0 to 31. Every setting maps to a tap inside the storage, at index BASE_DELAY-1 + addr*STEP_CYCLES.
- R2: While enabled and with `addr` held, `dout` in the cycle after rising edge n equals `din` as sampled at edge n-D+1, where D = BASE_DELAY + addr*STEP_CYCLES. A one-cycle pulse on `din` therefore shows up on `dout` D cycles later. Moving `addr` up by one lengthens D by exactly STEP_CYCLES.
- R3: The delay rises strictly with the address over the whole range 0 to 31.
- R4: At address 31 the delay is BASE_DELAY + 31*STEP_CYCLES cycles. This is the full length of the storage.
- R5: While `disableOut` is 1, `dout` is 0 in that same cycle, whatever the stored data.
- R6: The disable does not stop capture. Bits presented on `din` while `disableOut` is 1 appear on `dout` at their normal delay once `disableOut` returns to 0.
- R7: `addr` is not registered. A change of `addr` changes `dout` in the same cycle to the stored bit at the new tap.
- R8: A synchronous reset (`rst` = 1 at a rising edge) clears every stored bit. `dout` is 0 while `rst` is 1, and no bit captured before the reset ever reaches `dout`.
- R9: At address 0 the delay is BASE_DELAY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Bit to be delayed |
| addr | input | 5 | Delay setting, applied without capture |
| disableOut | input | 1 | Forces dout low while 1 |
| dout | output | 1 | Delayed bit |

## Verification
Suppose the tap index is wrong or a shift stage is miswired. Then `dout` shows a pulse one or more cycles early or late, or shows no pulse at all. The first mismatch appears within one full line length of the first stimulus, at most BASE_DELAY + 31*STEP_CYCLES cycles. A disable or reset that reaches the storage instead of only the output gives a different symptom: stored history is lost, and zeros appear on `dout` after the disable is released or after reset where ones are expected. A reset that fails to clear lets stale ones appear within one line length. Because the address has no capture register, a stale address register would show up at the port as a one-cycle lag on every address change.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef struct packed {
    logic clearAll;
    logic outEnable;
  } dlyStrobe_t;
endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BASE_DELAY  = 2,
  parameter int STEP_CYCLES = 3,
  parameter int LINE_LEN    = BASE_DELAY + ((1 << ADDR_W) - 1) * STEP_CYCLES,
  parameter int TAP_W       = $clog2(LINE_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              disableOut,
  output dlyStrobe_t        strobe,
  output logic [TAP_W-1:0]  tapIdx
);
  localparam logic [TAP_W-1:0] TAP_BASE = TAP_W'(BASE_DELAY - 1);
  localparam logic [TAP_W-1:0] TAP_STEP = TAP_W'(STEP_CYCLES);
  localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(LINE_LEN - 1);

  // Address goes straight to the tap: no capture register.
  always_comb begin
    tapIdx = TAP_BASE + TAP_W'(addr) * TAP_STEP;
  end

  always_comb begin
    strobe.clearAll  = rst;
    strobe.outEnable = ~rst & ~disableOut;
  end

  assert_tap_range_R1 : assert property (@(posedge clk) disable iff (rst)
    tapIdx <= TAP_LAST);

  assert_monotonic_R3 : assert property (@(posedge clk) disable iff (rst)
    (addr > $past(addr)) |-> (tapIdx > $past(tapIdx)));

  assert_step_size_R2 : assert property (@(posedge clk) disable iff (rst)
    ({1'b0, addr} == ({1'b0, $past(addr)} + (ADDR_W+1)'(1)))
      |-> (tapIdx == $past(tapIdx) + TAP_STEP));
endmodule

// File: rtl/dly_path.sv
module dly_path
  import dly_pkg::*;
#(
  parameter int LINE_LEN = 95,
  parameter int TAP_W    = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             din,
  input  dlyStrobe_t       strobe,
  input  logic [TAP_W-1:0] tapIdx,
  output logic             dout
);
  logic [LINE_LEN-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) shiftReg[0] <= 1'b0;
    else                 shiftReg[0] <= din;
  end

  for (genvar g = 1; g < LINE_LEN; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (strobe.clearAll) shiftReg[g] <= 1'b0;
      else                 shiftReg[g] <= shiftReg[g-1];
    end
  end

  always_comb begin
    dout = strobe.outEnable & shiftReg[tapIdx];
  end

  assert_reset_clears_R8 : assert property (@(posedge clk) disable iff (strobe.clearAll)
    $past(strobe.clearAll) |-> (shiftReg[LINE_LEN-1:1] == '0));
endmodule

// File: rtl/delay_line_prog.sv
module delay_line_prog
  import dly_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BASE_DELAY  = 2,
  parameter int STEP_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              disableOut,
  output logic              dout
);
  localparam int LINE_LEN = BASE_DELAY + ((1 << ADDR_W) - 1) * STEP_CYCLES;
  localparam int TAP_W    = $clog2(LINE_LEN);

  dlyStrobe_t       strobe;
  logic [TAP_W-1:0] tapIdx;

  dly_ctrl #(
    .ADDR_W(ADDR_W), .BASE_DELAY(BASE_DELAY), .STEP_CYCLES(STEP_CYCLES),
    .LINE_LEN(LINE_LEN), .TAP_W(TAP_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .addr(addr), .disableOut(disableOut),
    .strobe(strobe), .tapIdx(tapIdx)
  );

  dly_path #(.LINE_LEN(LINE_LEN), .TAP_W(TAP_W)) uPath (
    .clk(clk), .din(din), .strobe(strobe), .tapIdx(tapIdx), .dout(dout)
  );

  assert_disable_low_R5 : assert property (@(posedge clk) disable iff (rst)
    disableOut |-> !dout);
endmodule

// File: tb/sim_delay_line_prog.sv
`timescale 1ns/1ps
module sim_delay_line_prog;
  localparam int BASE  = 2;
  localparam int STEP  = 3;
  localparam int LEN   = BASE + 31 * STEP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [4:0] addr = '0;
  logic disableOut = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit hist[$];   // hist[0] = din captured at the latest edge

  always #4 clk = ~clk;

  delay_line_prog #(.ADDR_W(5), .BASE_DELAY(BASE), .STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst(rst), .din(din), .addr(addr),
    .disableOut(disableOut), .dout(dout)
  );

  function automatic int delayOf(input logic [4:0] a);
    return BASE + int'(a) * STEP;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: advance one edge, record what the line captured, apply new
  // inputs, then the monitor compares dout with the scoreboard at negedge.
  task automatic step(input logic d, input logic [4:0] a, input logic dis,
                      input logic r, input string req);
    logic exp;
    @(posedge clk);
    if (rst) begin
      hist.delete();
      for (int i = 0; i < LEN; i++) hist.push_back(1'b0);
    end else begin
      hist.push_front(din);
      void'(hist.pop_back());
    end
    #1;
    din = d; addr = a; disableOut = dis; rst = r;
    @(negedge clk);
    exp = (rst || disableOut) ? 1'b0 : hist[delayOf(addr) - 1];
    check(req, dout, exp);
  endtask

  task automatic measure(input logic [4:0] a, output int lat);
    for (int i = 0; i < LEN + 2; i++) step(1'b0, a, 1'b0, 1'b0, "R2");
    step(1'b1, a, 1'b0, 1'b0, "R2");
    lat = -1;
    for (int n = 1; n <= LEN + 2; n++) begin
      step(1'b0, a, 1'b0, 1'b0, "R2");
      if (dout === 1'b1 && lat < 0) lat = n;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, prevLat;
    for (int i = 0; i < LEN; i++) hist.push_back(1'b0);

    // R8: reset with ones on din, output must stay low
    for (int i = 0; i < 4; i++) step(1'b1, 5'd31, 1'b0, 1'b1, "R8");

    // R9 / R2: address 0 with a mixed pattern
    for (int i = 0; i < 60; i++) step(1'($urandom_range(0, 1)), 5'd0, 1'b0, 1'b0, "R9");
    measure(5'd0, lat);
    check("R9", 1'(lat == BASE), 1'b1);

    // R3 / R4 / R2: latency per address, strictly rising
    prevLat = 0;
    for (int a = 0; a < 32; a += 5) begin
      measure(5'(a), lat);
      check("R2", 1'(lat == delayOf(5'(a))), 1'b1);
      check("R3", 1'(lat > prevLat), 1'b1);
      prevLat = lat;
    end
    measure(5'd31, lat);
    check("R4", 1'(lat == BASE + 31 * STEP), 1'b1);

    // R2: random data at several fixed addresses
    for (int k = 0; k < 4; k++) begin
      logic [4:0] a = 5'($urandom_range(0, 31));
      for (int i = 0; i < 150; i++) step(1'($urandom_range(0, 1)), a, 1'b0, 1'b0, "R2");
    end

    // R5 / R6: disable window, history must survive it
    for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 5'd10, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 120; i++) step(1'($urandom_range(0, 1)), 5'd10, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 10; i++) step(1'b1, 5'd3, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 30; i++) step(1'b0, 5'd3, 1'b0, 1'b0, "R6");

    // R7: address changes every few cycles, tap moves at once
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a = (i % 3 == 0) ? 5'($urandom_range(0, 31)) : addr;
      step(1'($urandom_range(0, 1)), a, 1'b0, 1'b0, "R7");
    end
    for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 1'b0, 1'b0, "R7");

    // R8: fill with ones, reset mid-stream, nothing stale may emerge
    for (int i = 0; i < LEN + 5; i++) step(1'b1, 5'd31, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 2; i++) step(1'b1, 5'd31, 1'b0, 1'b1, "R8");
    for (int i = 0; i < LEN + 5; i++) begin
      step(1'b0, 5'($urandom_range(0, 31)), 1'b0, 1'b0, "R8");
      check("R8", dout, 1'b0);
    end
    check("R1", 1'(delayOf(5'd31) - 1 <= LEN - 1), 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule